// File: doc/BRIEF.md
# Delayed Power-Up Output Sequencer

This block drives three active-low enable outputs that bring up downstream supplies in a programmed order. It watches a digital supply-good signal for the primary rail, which an analog comparator elsewhere produces. Once that signal is seen high, each output waits for its own programmed number of millisecond ticks and then drives low. If the primary rail is lost, every output goes back high together and all delay counts start again from zero.

Two configuration bytes come from a register file outside the block. A mode byte holds an active-low sequencing-enable bit. A delay byte holds one 2-bit delay code per output. With sequencing turned off, the outputs simply follow supply-good. The block runs on a system clock. A separate single-cycle pulse marks each millisecond, and the length of one delay unit in ticks is a parameter.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst` is high, `en_n` reads 3'b111 at every clock edge, whatever the other inputs are.
- R2: At any clock edge that samples `supply_ok` low, all three `en_n` bits go high, and all delay counts return to zero.
- R3: When `mode_reg[7]` is 1, sequencing is off. At each clock edge, all `en_n` bits go low when `supply_ok` is sampled high and go high when it is sampled low.
- R4: With `mode_reg[7]` = 0, a delay code maps to a number of ticks: 2'b00 gives 0, 2'b01 gives 25, 2'b10 gives 50 and 2'b11 gives 100. This holds at the default `UNIT_TICKS` = 25.
- R5: The code for `en_n[0]` is `delay_reg[1:0]`, the code for `en_n[1]` is `delay_reg[3:2]` and the code for `en_n[2]` is `delay_reg[5:4]`. `delay_reg[7:6]` has no effect on any output.
- R6: A tick counts when the clock edge samples both `ms_tick` and `supply_ok` high. Each output goes low on the clock edge after the edge that counted its N-th tick. A code of 00 releases the output on the first edge that samples `supply_ok` high.
- R7: Each output counts its delay on its own, from the same starting moment. Outputs with equal codes go low on the same clock edge.
- R8: An output that has gone low stays low while `supply_ok` stays high and the configuration does not change.
- R9: Ticks that arrive while `supply_ok` is low are not counted toward any later release.
- R10: `mode_reg[6:0]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| supply_ok | input | 1 | Primary supply qualified (active high) |
| mode_reg | input | 8 | Mode byte; bit 7 = 1 turns sequencing off |
| delay_reg | input | 8 | Delay codes for the three outputs, in bits 5:0 |
| en_n | output | 3 | Active-low enables; bit 0 is output 1 |

## Verification
The hold and equal-code assertions assume that `mode_reg` and `delay_reg` change only while `supply_ok` is low or while the block is in reset. The hold property also checks for this directly with `$stable`. The bench keeps to this assumption: it writes a new configuration only after it has driven `supply_ok` low or asserted reset. The assertions also assume that `ms_tick` is a clean synchronous pulse. The bench drives the tick on one cycle in four, and drives it from the falling edge.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    localparam int NUM_OUT = 3;
    localparam int CODE_W  = 2;

    typedef logic [CODE_W-1:0] dly_code_t;

    typedef struct packed {
        logic                    seq_on;
        dly_code_t [NUM_OUT-1:0] code;
    } seq_cfg_t;

    // Delay length in units for a 2-bit code: 0, 1, 2 or 4 units.
    function automatic int unsigned code_units(input dly_code_t c);
        case (c)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/pwrup_seq_cfg_dec.sv
module pwrup_seq_cfg_dec
    import pwrup_seq_pkg::*;
(
    input  logic [7:0] mode_reg,
    input  logic [7:0] delay_reg,
    output seq_cfg_t   cfg
);
    // The sequencing-enable bit is active low.
    always_comb begin
        cfg.seq_on = ~mode_reg[7];
        for (int i = 0; i < NUM_OUT; i++) begin
            cfg.code[i] = delay_reg[CODE_W*i +: CODE_W];
        end
    end
endmodule

// File: rtl/pwrup_seq_chan.sv
module pwrup_seq_chan
    import pwrup_seq_pkg::*;
#(
    parameter int UNIT_TICKS = 25
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      supply_ok,
    input  logic      ms_tick,
    input  logic      seq_on,
    input  dly_code_t code,
    output logic      en_n
);
    localparam int MAX_TICKS = 4 * UNIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] target;
    logic             reached;

    always_comb begin
        target  = CNT_W'(code_units(code) * UNIT_TICKS);
        reached = (elapsed >= target);
    end

    // Count ticks since supply qualified; saturate at the longest delay.
    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            elapsed <= '0;
        end else if (ms_tick && (elapsed < CNT_W'(MAX_TICKS))) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_n <= 1'b1;
        end else begin
            en_n <= ~(supply_ok && (!seq_on || reached));
        end
    end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int UNIT_TICKS = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic       supply_ok,
    input  logic [7:0] mode_reg,
    input  logic [7:0] delay_reg,
    output logic [2:0] en_n
);
    seq_cfg_t cfg;

    pwrup_seq_cfg_dec u_dec (
        .mode_reg  (mode_reg),
        .delay_reg (delay_reg),
        .cfg       (cfg)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        pwrup_seq_chan #(.UNIT_TICKS(UNIT_TICKS)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .supply_ok (supply_ok),
            .ms_tick   (ms_tick),
            .seq_on    (cfg.seq_on),
            .code      (cfg.code[g]),
            .en_n      (en_n[g])
        );
    end
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ms_tick,
    input logic       supply_ok,
    input logic [7:0] mode_reg,
    input logic [7:0] delay_reg,
    input logic [2:0] en_n
);
    assert_sup_low_R2: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (en_n == 3'b111));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && mode_reg[7]) |=> (en_n == 3'b000));

    assert_zero_code_R6: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && delay_reg[1:0] == 2'b00) |=> !en_n[0]);

    assert_equal_codes_R7: assert property (@(posedge clk) disable iff (rst)
        (delay_reg[1:0] == delay_reg[3:2]) |=> (en_n[0] == en_n[1]));

    for (genvar k = 0; k < 3; k++) begin : g_hold
        assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (!en_n[k] && supply_ok && $stable(delay_reg) && $stable(mode_reg[7]))
            |=> !en_n[k]);
    end
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ms_tick   (ms_tick),
    .supply_ok (supply_ok),
    .mode_reg  (mode_reg),
    .delay_reg (delay_reg),
    .en_n      (en_n)
);

// File: tb/tb_pwrup_seq.sv
module tb_pwrup_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       supply_ok = 1'b0;
    logic [7:0] mode_reg = 8'h00;
    logic [7:0] delay_reg = 8'h00;
    logic [2:0] en_n;

    int checks = 0;
    int errors = 0;
    int mcnt   = 0;
    int rel [3];
    logic [2:0] exp_en = 3'b111;

    always #2 clk = ~clk;

    pwrup_seq dut (
        .clk       (clk),
        .rst       (rst),
        .ms_tick   (ms_tick),
        .supply_ok (supply_ok),
        .mode_reg  (mode_reg),
        .delay_reg (delay_reg),
        .en_n      (en_n)
    );

    // Stimulus bytes and expected release tick counts per output.
    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] dly;
        logic [6:0] t1;
        logic [6:0] t2;
        logic [6:0] t3;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'b00_11_10_01, 7'd25,  7'd50,  7'd100},
        '{8'h7F, 8'b11_00_01_10, 7'd50,  7'd25,  7'd0  },
        '{8'h00, 8'b00_10_10_10, 7'd50,  7'd50,  7'd50 },
        '{8'h80, 8'b11_11_11_11, 7'd0,   7'd0,   7'd0  },
        '{8'h00, 8'b00_00_00_00, 7'd0,   7'd0,   7'd0  },
        '{8'h55, 8'b01_01_11_00, 7'd0,   7'd100, 7'd25 }
    };

    task automatic step(input logic tick, input string tag);
        ms_tick = tick;
        @(posedge clk);
        if (rst || !supply_ok) begin
            exp_en = 3'b111;
            mcnt   = 0;
        end else begin
            for (int i = 0; i < 3; i++) exp_en[i] = !(mcnt >= rel[i]);
            if (ms_tick) mcnt++;
        end
        @(negedge clk);
        checks++;
        if (en_n !== exp_en) begin
            errors++;
            $display("FAIL %s: en_n=%b expected=%b (ticks=%0d)", tag, en_n, exp_en, mcnt);
        end
    endtask

    task automatic run_ticks(input int n, input string tag);
        for (int c = 0; c < 4 * n; c++) step((c % 4) == 3, tag);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds outputs high even with supply good and bypass on.
        rel = '{0, 0, 0};
        @(negedge clk);
        supply_ok = 1'b1;
        mode_reg  = 8'h80;
        for (int c = 0; c < 6; c++) step(c[0], "R1 reset state");
        supply_ok = 1'b0;
        rst = 1'b0;
        step(1'b0, "R1 reset release");

        // Vector walk: R3 R4 R5 R6 R7 R10.
        for (int v = 0; v < NV; v++) begin
            supply_ok = 1'b0;
            mode_reg  = VECS[v].mode;
            delay_reg = VECS[v].dly;
            rel = '{int'(VECS[v].t1), int'(VECS[v].t2), int'(VECS[v].t3)};
            run_ticks(1, "R2 idle low");
            supply_ok = 1'b1;
            run_ticks(110, "R3 R4 R5 R6 R7 R10 vector");
        end

        // R2 and R9: drop mid-sequence, ticks while low, full restart.
        supply_ok = 1'b0;
        mode_reg  = 8'h00;
        delay_reg = 8'b00_11_10_01;
        rel = '{25, 50, 100};
        step(1'b0, "R2 setup");
        supply_ok = 1'b1;
        run_ticks(30, "R6 before drop");
        supply_ok = 1'b0;
        step(1'b0, "R2 drop all high");
        run_ticks(10, "R9 ticks while low");
        supply_ok = 1'b1;
        run_ticks(60, "R9 R2 restart full delay");
        run_ticks(50, "R8 hold released");

        // R2: drop exactly on a tick edge.
        supply_ok = 1'b0;
        step(1'b1, "R2 drop on tick");
        step(1'b0, "R2 stays high");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule